// File: doc/BRIEF.md
# Post-Configuration Input Blanking Controller

Right after a device finishes configuration, some input pins can show a short 0-1-0 pulse about one configuration-clock period after the end-of-startup flag rises. The pins are clean again within a fixed time of that flag. This controller keeps downstream logic from seeing that pulse. It starts a guard interval on the end-of-startup flag rather than on a reset, and holds an active-low ignore signal low until the interval has passed. The guard length is set in nanoseconds together with the logic clock frequency.

The end-of-startup flag is asynchronous to the logic clock. It is brought in through a two-flop synchronizer and then starts a saturating counter. A registered flag releases the ignore signal on a logic-clock edge, so the protected logic always sees a clean, whole-cycle transition. A build-time parameter picks one of two protection styles. In the masking style, the affected inputs are forced to an inactive level while blanked. In the enable-holding style, the inputs pass through unchanged and the clock enable of the protected logic is held low until release.

Top module: `pib_blanking_ctrl`

## Requirements
- R1: While reset is high and on the first cycles after it, `ignore_n_o` is 0. In enable-holding mode `clk_en_o` is 0. In masking mode every bit of `gated_o` equals `INACTIVE_LVL`.
- R2: As long as `eos_i` has not been sampled high, `ignore_n_o` stays 0 for any length of time, whatever `raw_i` does.
- R3: The terminal count is TC = ceil(GUARD_NS × CLK_MHZ / 1000) + MARGIN. `ignore_n_o` goes to 1 on the (TC+3)-th rising clock edge, counting the first edge that samples `eos_i` high as edge 1. The delay is two synchronizer edges, TC counting edges and one output-register edge. It is never 1 earlier.
- R4: The blanking time, (TC+2) clock periods, is at least GUARD_NS.
- R5: Once `ignore_n_o` is 1, it stays 1 until reset, even if `eos_i` falls again.
- R6: In masking mode (MODE = BLANK_MASK), every bit of `gated_o` equals `INACTIVE_LVL` while `ignore_n_o` is 0. This includes a 0-1-0 pulse on `raw_i` shortly after `eos_i` rises.
- R7: In masking mode, `gated_o` equals `raw_i` in the same cycle once `ignore_n_o` is 1, and `clk_en_o` is always 1.
- R8: In enable-holding mode (MODE = BLANK_HOLD_CE), `gated_o` always equals `raw_i`. `clk_en_o` equals `ignore_n_o`, so a register enabled by it captures nothing before release.
- R9: An `eos_i` pulse that is sampled high on just one clock edge still completes the full window, with the same release timing as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock of the protected logic |
| rst_i | input | 1 | Synchronous active-high reset |
| eos_i | input | 1 | End-of-startup flag, active high, asynchronous |
| raw_i | input | N_IN | Affected input pins |
| ignore_n_o | output | 1 | Active-low ignore signal, registered |
| gated_o | output | N_IN | Inputs as seen by the user logic |
| clk_en_o | output | 1 | Clock enable for the protected logic |

## Verification
Three instances run from the same stimulus: masking with a low inactive level, masking with a high inactive level, and enable-holding. The two masking levels tell a real mask apart from a wire that only happens to read zero.

The inputs change every cycle in several ways:
- A long idle stretch with no end-of-startup shows that nothing starts without the flag.
- A window opened by a held flag has a 0-1-0 pulse placed one cycle after the flag rises, followed by a sweep of values. It checks the exact release edge and shows that the pulse is absorbed both by masking and by an enable-gated capture register.
- After release, all sixteen input codes are swept with the flag dropped, which tests pass-through and shows the ignore signal does not re-arm.
- A window opened by a single-edge flag pulse confirms that a brief flag still completes the full interval.

// File: rtl/pib_pkg.sv
package pib_pkg;

    typedef enum logic {
        BLANK_MASK    = 1'b0,
        BLANK_HOLD_CE = 1'b1
    } blank_mode_e;

    typedef struct packed {
        logic ign_n;
        logic ce;
    } blank_ctl_t;

    function automatic int guard_cycles(input int guard_ns, input int clk_mhz,
                                        input int margin);
        return (guard_ns * clk_mhz + 999) / 1000 + margin;
    endfunction

    function automatic int cnt_width(input int tc);
        return (tc < 2) ? 1 : $clog2(tc + 1);
    endfunction

endpackage

// File: rtl/pib_eos_sync.sv
module pib_eos_sync (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/pib_guard_timer.sv
module pib_guard_timer #(
    parameter int TC = 22,
    parameter int CW = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic ign_n_o
);
    localparam logic [CW-1:0] TERM = CW'(TC);

    logic [CW-1:0] cnt_q;
    logic          ign_q;
    logic          advance;

    assign advance = (start_i || cnt_q != '0) && (cnt_q != TERM);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            ign_q <= 1'b0;
        end else begin
            if (advance) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == TERM) ign_q <= 1'b1;
        end
    end

    assign ign_n_o = ign_q;

    // R5: released state is sticky
    a_r5_no_reassert: assert property (@(posedge clk_i) disable iff (rst_i)
        ign_q |=> ign_q);
    // R3: release only follows the terminal count
    a_r3_release_at_tc: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ign_q) |-> $past(cnt_q) == TERM);
    // R3 / R9: once started the counter steps by one every cycle
    a_r9_count_steps: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q != '0 && cnt_q != TERM) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R2: idle without a start request
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!start_i && cnt_q == '0) |=> (cnt_q == '0 && !ign_q));
    // R5: counter saturates
    a_r5_saturate: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == TERM) |=> cnt_q == TERM);
endmodule

// File: rtl/pib_input_gate.sv
module pib_input_gate #(
    parameter int                  N_IN         = 4,
    parameter logic                INACTIVE_LVL = 1'b0,
    parameter pib_pkg::blank_mode_e MODE        = pib_pkg::BLANK_MASK
) (
    input  logic            ign_n_i,
    input  logic [N_IN-1:0] raw_i,
    output logic [N_IN-1:0] gated_o,
    output logic            ce_o
);
    localparam logic [N_IN-1:0] IDLE_VEC = {N_IN{INACTIVE_LVL}};

    generate
        if (MODE == pib_pkg::BLANK_MASK) begin : g_mask
            for (genvar i = 0; i < N_IN; i++) begin : g_bit
                assign gated_o[i] = ign_n_i ? raw_i[i] : IDLE_VEC[i];
            end
            assign ce_o = 1'b1;
        end else begin : g_hold
            assign gated_o = raw_i;
            assign ce_o    = ign_n_i;
        end
    endgenerate
endmodule

// File: rtl/pib_blanking_ctrl.sv
module pib_blanking_ctrl #(
    parameter int                   N_IN         = 4,
    parameter int                   CLK_MHZ      = 100,
    parameter int                   GUARD_NS     = 200,
    parameter int                   MARGIN       = 2,
    parameter logic                 INACTIVE_LVL = 1'b0,
    parameter pib_pkg::blank_mode_e MODE         = pib_pkg::BLANK_MASK
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            eos_i,
    input  logic [N_IN-1:0] raw_i,
    output logic            ignore_n_o,
    output logic [N_IN-1:0] gated_o,
    output logic            clk_en_o
);
    localparam int TC = pib_pkg::guard_cycles(GUARD_NS, CLK_MHZ, MARGIN);
    localparam int CW = pib_pkg::cnt_width(TC);
    localparam logic [N_IN-1:0] IDLE_VEC = {N_IN{INACTIVE_LVL}};

    logic                eos_s;
    pib_pkg::blank_ctl_t ctl;

    pib_eos_sync u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (eos_i),
        .sync_o  (eos_s)
    );

    pib_guard_timer #(.TC(TC), .CW(CW)) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (eos_s),
        .ign_n_o (ctl.ign_n)
    );

    pib_input_gate #(.N_IN(N_IN), .INACTIVE_LVL(INACTIVE_LVL), .MODE(MODE)) u_gate (
        .ign_n_i (ctl.ign_n),
        .raw_i   (raw_i),
        .gated_o (gated_o),
        .ce_o    (ctl.ce)
    );

    assign ignore_n_o = ctl.ign_n;
    assign clk_en_o   = ctl.ce;

    // R6: masked inputs read inactive while blanked
    a_r6_mask_blank: assert property (@(posedge clk_i) disable iff (rst_i)
        (MODE == pib_pkg::BLANK_MASK && !ignore_n_o) |-> gated_o == IDLE_VEC);
    // R7: pass-through after release in masking mode
    a_r7_pass_after: assert property (@(posedge clk_i) disable iff (rst_i)
        (MODE == pib_pkg::BLANK_MASK && ignore_n_o) |-> (gated_o == raw_i && clk_en_o));
    // R8: enable follows the ignore signal in enable-holding mode
    a_r8_ce_tracks: assert property (@(posedge clk_i) disable iff (rst_i)
        (MODE == pib_pkg::BLANK_HOLD_CE) |-> (clk_en_o == ignore_n_o && gated_o == raw_i));
    // R4: window covers the guard time
    a_r4_window_len: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |-> ((TC + 2) * 1000 >= GUARD_NS * CLK_MHZ));
endmodule

// File: tb/pib_blanking_ctrl_tb_top.sv
module pib_blanking_ctrl_tb_top;
    localparam int PERIOD_NS = 10;
    localparam int N_IN      = 4;
    localparam int CLK_MHZ   = 1000 / PERIOD_NS;
    localparam int GUARD_NS  = 200;
    localparam int MARGIN    = 2;
    localparam int TC_EXP    = (GUARD_NS * CLK_MHZ + 999) / 1000 + MARGIN;
    localparam int REL_EDGE  = TC_EXP + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eos = 1'b0;
    logic [N_IN-1:0] raw = '0;

    logic ign_lo, ign_hi, ign_ce;
    logic [N_IN-1:0] g_lo, g_hi, g_ce;
    logic ce_lo, ce_hi, ce_ce;
    logic [N_IN-1:0] cap;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD_NS/2) clk = ~clk;

    pib_blanking_ctrl #(.N_IN(N_IN), .CLK_MHZ(CLK_MHZ), .GUARD_NS(GUARD_NS),
        .MARGIN(MARGIN), .INACTIVE_LVL(1'b0), .MODE(pib_pkg::BLANK_MASK)) dut_i (
        .clk_i(clk), .rst_i(rst), .eos_i(eos), .raw_i(raw),
        .ignore_n_o(ign_lo), .gated_o(g_lo), .clk_en_o(ce_lo));

    pib_blanking_ctrl #(.N_IN(N_IN), .CLK_MHZ(CLK_MHZ), .GUARD_NS(GUARD_NS),
        .MARGIN(MARGIN), .INACTIVE_LVL(1'b1), .MODE(pib_pkg::BLANK_MASK)) dut_hi_i (
        .clk_i(clk), .rst_i(rst), .eos_i(eos), .raw_i(raw),
        .ignore_n_o(ign_hi), .gated_o(g_hi), .clk_en_o(ce_hi));

    pib_blanking_ctrl #(.N_IN(N_IN), .CLK_MHZ(CLK_MHZ), .GUARD_NS(GUARD_NS),
        .MARGIN(MARGIN), .INACTIVE_LVL(1'b0), .MODE(pib_pkg::BLANK_HOLD_CE)) dut_ce_i (
        .clk_i(clk), .rst_i(rst), .eos_i(eos), .raw_i(raw),
        .ignore_n_o(ign_ce), .gated_o(g_ce), .clk_en_o(ce_ce));

    // enabled logic under protection in enable-holding mode
    always @(posedge clk) begin
        if (rst) cap <= '0;
        else if (ce_ce) cap <= g_ce;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // compare all outputs given the expected released state
    task automatic chk_all(input string req, input bit rel);
        chk(req, "ignore_n lo", int'(ign_lo), int'(rel));
        chk(req, "ignore_n hi", int'(ign_hi), int'(rel));
        chk(req, "ignore_n ce", int'(ign_ce), int'(rel));
        chk(rel ? "R7" : "R6", "gated lo", int'(g_lo), rel ? int'(raw) : 0);
        chk(rel ? "R7" : "R6", "gated hi", int'(g_hi), rel ? int'(raw) : (1 << N_IN) - 1);
        chk("R7", "clk_en lo", int'(ce_lo), 1);
        chk("R7", "clk_en hi", int'(ce_hi), 1);
        chk("R8", "gated ce", int'(g_ce), int'(raw));
        chk("R8", "clk_en ce", int'(ce_ce), int'(rel));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; eos = 1'b0; raw = '0;
        repeat (3) @(negedge clk);
        #1;
        chk_all("R1", 1'b0);
        rst = 1'b0;
    endtask

    // run a window; short_eos keeps eos high across one edge only
    task automatic run_window(input bit short_eos, input string req);
        @(negedge clk);
        eos = 1'b1;
        raw = '0;
        for (int n = 1; n <= REL_EDGE + 6; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (short_eos) eos = 1'b0;
            // 0-1-0 pulse right after eos rises, then a sweep
            if (n == 1) raw = '1;
            else if (n == 2) raw = '0;
            else raw = N_IN'(n * 5);
            #1;
            chk_all(req, n >= REL_EDGE);
            if (n <= REL_EDGE)
                chk("R8", "capture stays clear", int'(cap), 0);
        end
    endtask

    initial begin
        logic [N_IN-1:0] prev;
        // R4: guard interval covered
        chk("R4", "window ns", ((TC_EXP + 2) * PERIOD_NS >= GUARD_NS) ? 1 : 0, 1);

        do_reset();
        // R2: long idle, no eos, inputs toggling
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            raw = N_IN'(k * 7 + 3);
            #1;
            chk_all("R2", 1'b0);
        end

        // R3 / R6 / R8: held eos with pulse
        run_window(1'b0, "R3");

        // R5 / R7: eos dropped, sweep all codes
        @(negedge clk);
        eos = 1'b0;
        prev = raw;
        for (int v = 0; v < 40; v++) begin
            @(negedge clk);
            chk("R8", "capture follows", int'(cap), int'(prev));
            raw = N_IN'(v);
            prev = raw;
            #1;
            chk_all("R5", 1'b1);
        end

        // R9: single-edge eos pulse
        do_reset();
        repeat (5) @(negedge clk);
        run_window(1'b1, "R9");

        summary();
    end

    initial begin
        #(PERIOD_NS * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end
endmodule